// File: doc/BRIEF.md
# Prescaled Reloadable Timer Time Base

This block is the counting core of a general-purpose timer. A 16-bit prescaler turns the timer clock into a count-enable strobe. A counter then steps on each strobe, upward, downward, or alternately up and down (centre-aligned). The counter is 16 bits wide and can be widened to 32. Each time the counter turns around, the block raises a one-cycle overflow pulse and sets a sticky flag. Software can request the same pulse through a register write.

Software configures the block through a single write port with four word addresses. The divisor and the period each sit in a staging register behind an active copy. The active divisor changes only on an overflow pulse. The active period changes either at once or only on an overflow pulse, as a control bit selects. When the overflow pulse is turned off, both active copies stay as they are. The run bit is registered once before it reaches the prescaler, so counting starts one clock after the write.

The counter direction is held in a two-state machine. RISE means the counter is going up and FALL means it is going down. In up mode the machine stays in RISE and in down mode it stays in FALL. In centre mode the transition RISE→FALL is taken when the counter reaches the period, and the transition FALL→RISE is taken when it reaches zero. A software restart forces FALL in down mode and RISE in every other mode.

Top module: `tmb_timebase`

## Requirements
- R1: After reset, cnt_value, ovf_flag, ovf_pulse and run_active are all 0. Every register and both active copies are also 0.
- R2: Register map: address 0 is control, 1 is divisor, 2 is period, 3 is flag. The run bit is control bit 0. run_active goes high one clock after the write that sets run, and goes low one clock after the write that clears it. While run_active is 0, the counter holds its value.
- R3: The prescaler produces one cnt_tick every N+1 clocks while running, where N is the active divisor. The counter changes only on a tick.
- R4: A write to the divisor (address 2'd1, bits 15:0) leaves the prescaler rate unchanged until the next overflow pulse. On that pulse the new divisor becomes active and the prescaler count restarts from 0.
- R5: Up mode is control bits 5:4 = 00. The counter steps 0,1,…,P, where P is the active period. On the tick after P it returns to 0 and ovf_pulse is high.
- R6: Down mode is control bits 5:4 = 01. The counter steps down to 0. On the tick after 0 it reloads P and ovf_pulse is high.
- R7: Centre mode is control bits 5:4 = 1x. The counter rises to P and then falls to 0. ovf_pulse is high on the tick that reaches P and on the tick that reaches 0. When P=0, every tick gives a pulse.
- R8: Period-buffer bit is control bit 1. When it is 0, a write to the period (address 2'd2) takes effect at once. When it is 1, the written value becomes active only on an overflow pulse.
- R9: Event-off bit is control bit 2. When it is 1, no ovf_pulse is produced and the flag is not set. Neither the divisor nor the period is transferred to its active copy. The counter still wraps.
- R10: A write to address 2'd3 with data bit 1 set is a software update request. When source-select (control bit 3) is 0, the request produces an overflow pulse. It also restarts the counter: to 0, or to the period in down mode. When source-select is 1, the request is ignored.
- R11: ovf_flag is set by every overflow pulse and holds its value. Writing address 2'd3 with data bit 0 = 0 clears it, and writing 1 has no effect. An overflow pulse in the same cycle as a clear leaves the flag set.
- R12: Wide bit is control bit 6. When it is 1, the counter and period use all 32 bits. When it is 0, only bits 15:0 of the period are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word address |
| wr_data | input | 32 | Write data |
| cnt_value | output | 32 | Current counter value |
| cnt_tick | output | 1 | Prescaler count-enable strobe |
| ovf_pulse | output | 1 | Overflow event, one clock wide |
| ovf_flag | output | 1 | Sticky overflow flag |
| run_active | output | 1 | Synchronised run enable |

## Verification
If the divisor or period copy goes wrong, the fault shows as a changed tick spacing or a changed turnaround value. This appears at the first overflow after the bad transfer, within (N+1)(P+1) clocks. A wrong direction state in centre mode shows on cnt_value at the very next tick, because the counter moves the wrong way. A fault in flag or run synchronisation shows on ovf_flag or run_active within one clock of the write or pulse that should have changed it.

// File: rtl/tmb_pkg.sv
package tmb_pkg;

    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL = 2'd0,
        ADR_DIV  = 2'd1,
        ADR_PER  = 2'd2,
        ADR_FLAG = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        MODE_UP   = 2'b00,
        MODE_DOWN = 2'b01,
        MODE_CTR  = 2'b10,
        MODE_CTR2 = 2'b11
    } cnt_mode_e;

    typedef enum logic {
        ST_RISE = 1'b0,
        ST_FALL = 1'b1
    } dir_state_e;

    typedef struct packed {
        logic      wide;
        cnt_mode_e mode;
        logic      src_sel;
        logic      evt_off;
        logic      pbuf;
        logic      run;
    } ctrl_t;

endpackage

// File: rtl/tmb_regs.sv
module tmb_regs
    import tmb_pkg::*;
#(
    parameter int unsigned PSC_W = 16,
    parameter int unsigned FULL_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [FULL_W-1:0] wr_data,
    input  logic              evt,
    output ctrl_t             ctrl,
    output logic              run_q,
    output logic [PSC_W-1:0]  div_act,
    output logic [FULL_W-1:0] per_reg,
    output logic [FULL_W-1:0] per_act,
    output logic              flag,
    output logic              sw_req
);

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    logic             wr_ctrl, wr_div, wr_per, wr_flag;
    logic [PSC_W-1:0] div_reg;

    always_comb begin
        wr_ctrl = wr_en && (wr_addr == ADR_CTRL);
        wr_div  = wr_en && (wr_addr == ADR_DIV);
        wr_per  = wr_en && (wr_addr == ADR_PER);
        wr_flag = wr_en && (wr_addr == ADR_FLAG);
        sw_req  = wr_flag && wr_data[1];
    end

    // control word and the one-stage run synchroniser
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl  <= '0;
            run_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
            end
            run_q <= ctrl.run;
        end
    end

    // divisor: staged, moved to the active copy only on an event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_reg <= '0;
            div_act <= '0;
        end else begin
            if (wr_div) begin
                div_reg <= wr_data[PSC_W-1:0];
            end
            if (evt) begin
                div_act <= div_reg;
            end
        end
    end

    // period: direct or buffered by the pbuf bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_reg <= '0;
            per_act <= '0;
        end else begin
            if (wr_per) begin
                per_reg <= wr_data;
            end
            if (wr_per && !ctrl.pbuf) begin
                per_act <= wr_data;
            end else if (evt && ctrl.pbuf) begin
                per_act <= per_reg;
            end
        end
    end

    // sticky flag, set wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (evt) begin
            flag <= 1'b1;
        end else if (wr_flag && !wr_data[0]) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/tmb_prescaler.sv
module tmb_prescaler #(
    parameter int unsigned PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PSC_W-1:0] div,
    output logic             tick
);

    logic [PSC_W-1:0] psc_q;

    always_comb begin
        tick = run && (psc_q == div);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q <= '0;
        end else if (restart) begin
            psc_q <= '0;
        end else if (run) begin
            psc_q <= tick ? '0 : psc_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmb_counter.sv
module tmb_counter
    import tmb_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned FULL_W = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              restart,
    input  cnt_mode_e         mode,
    input  logic              wide,
    input  logic              swap_ok,
    input  logic [FULL_W-1:0] per_act,
    input  logic [FULL_W-1:0] per_reg,
    output logic [FULL_W-1:0] cnt,
    output logic              wrap
);

    localparam logic [FULL_W-1:0] ONE = FULL_W'(1);

    dir_state_e        state_q, state_d;
    logic [FULL_W-1:0] cnt_d;
    logic [FULL_W-1:0] per_e, load_e, cnt_m;

    function automatic logic [FULL_W-1:0] fit(input logic [FULL_W-1:0] v,
                                              input logic w);
        fit = w ? v : {{(FULL_W-CNT_W){1'b0}}, v[CNT_W-1:0]};
    endfunction

    always_comb begin
        per_e  = fit(per_act, wide);
        load_e = fit(swap_ok ? per_reg : per_act, wide);
        cnt_m  = fit(cnt, wide);
    end

    // next state, next count and the turnaround strobe
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt;
        wrap    = 1'b0;
        if (restart) begin
            if (mode == MODE_DOWN) begin
                cnt_d   = load_e;
                state_d = ST_FALL;
            end else begin
                cnt_d   = '0;
                state_d = ST_RISE;
            end
        end else if (tick) begin
            unique case (mode)
                MODE_UP: begin
                    state_d = ST_RISE;
                    if (cnt_m >= per_e) begin
                        cnt_d = '0;
                        wrap  = 1'b1;
                    end else begin
                        cnt_d = cnt_m + ONE;
                    end
                end
                MODE_DOWN: begin
                    state_d = ST_FALL;
                    if (cnt_m == '0) begin
                        cnt_d = load_e;
                        wrap  = 1'b1;
                    end else begin
                        cnt_d = cnt_m - ONE;
                    end
                end
                MODE_CTR, MODE_CTR2: begin
                    unique case (state_q)
                        ST_RISE: begin
                            if ((cnt_m >= per_e) || (cnt_m + ONE == per_e)) begin
                                cnt_d   = per_e;
                                state_d = ST_FALL;
                                wrap    = 1'b1;
                            end else begin
                                cnt_d = cnt_m + ONE;
                            end
                        end
                        ST_FALL: begin
                            if (cnt_m <= ONE) begin
                                cnt_d   = '0;
                                state_d = ST_RISE;
                                wrap    = 1'b1;
                            end else begin
                                cnt_d = cnt_m - ONE;
                            end
                        end
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RISE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_d;
        end
    end

endmodule

// File: rtl/tmb_timebase.sv
module tmb_timebase
    import tmb_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned PSC_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [2*CNT_W-1:0]   wr_data,
    output logic [2*CNT_W-1:0]   cnt_value,
    output logic                 cnt_tick,
    output logic                 ovf_pulse,
    output logic                 ovf_flag,
    output logic                 run_active
);

    localparam int unsigned FULL_W = 2 * CNT_W;

    ctrl_t             ctrl;
    logic              ctrl_run, evt_off, pbuf;
    logic [PSC_W-1:0]  div_act;
    logic [FULL_W-1:0] per_reg, per_act;
    logic              sw_req, sw_evt, wrap, evt;

    always_comb begin
        ctrl_run  = ctrl.run;
        evt_off   = ctrl.evt_off;
        pbuf      = ctrl.pbuf;
        sw_evt    = sw_req && !ctrl.src_sel && !ctrl.evt_off;
        evt       = sw_evt || (wrap && !ctrl.evt_off);
        ovf_pulse = evt;
    end

    tmb_regs #(.PSC_W(PSC_W), .FULL_W(FULL_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .evt     (evt),
        .ctrl    (ctrl),
        .run_q   (run_active),
        .div_act (div_act),
        .per_reg (per_reg),
        .per_act (per_act),
        .flag    (ovf_flag),
        .sw_req  (sw_req)
    );

    tmb_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_active),
        .restart (evt),
        .div     (div_act),
        .tick    (cnt_tick)
    );

    tmb_counter #(.CNT_W(CNT_W), .FULL_W(FULL_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (cnt_tick),
        .restart (sw_evt),
        .mode    (ctrl.mode),
        .wide    (ctrl.wide),
        .swap_ok (ctrl.pbuf && !ctrl.evt_off),
        .per_act (per_act),
        .per_reg (per_reg),
        .cnt     (cnt_value),
        .wrap    (wrap)
    );

endmodule

// File: rtl/tmb_checker.sv
module tmb_checker #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned PSC_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               run_active,
    input logic               cnt_tick,
    input logic [2*CNT_W-1:0] cnt_value,
    input logic               ovf_pulse,
    input logic               ovf_flag,
    input logic               ctrl_run,
    input logic               evt_off,
    input logic               pbuf,
    input logic               sw_evt,
    input logic [PSC_W-1:0]   div_act,
    input logic [2*CNT_W-1:0] per_act
);

    AST_RUN_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        run_active == $past(ctrl_run)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_active && !sw_evt) |=> $stable(cnt_value)); // R2

    AST_TICK_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_tick |-> run_active); // R3

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_pulse |=> $stable(div_act)); // R4

    AST_PER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pbuf && !ovf_pulse) |=> $stable(per_act)); // R8

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        evt_off |-> !ovf_pulse); // R9

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> ovf_flag); // R11

endmodule

bind tmb_timebase tmb_checker #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_active (run_active),
    .cnt_tick   (cnt_tick),
    .cnt_value  (cnt_value),
    .ovf_pulse  (ovf_pulse),
    .ovf_flag   (ovf_flag),
    .ctrl_run   (ctrl_run),
    .evt_off    (evt_off),
    .pbuf       (pbuf),
    .sw_evt     (sw_evt),
    .div_act    (div_act),
    .per_act    (per_act)
);

// File: tb/sim_tmb_timebase.sv
`timescale 1ns/1ps
module sim_tmb_timebase;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_DIV  = 2'd1;
    localparam logic [1:0] A_PER  = 2'd2;
    localparam logic [1:0] A_FLAG = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [31:0] wr_data;
    logic [31:0] cnt_value;
    logic        cnt_tick, ovf_pulse, ovf_flag, run_active;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    tmb_timebase u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cnt_value  (cnt_value),
        .cnt_tick   (cnt_tick),
        .ovf_pulse  (ovf_pulse),
        .ovf_flag   (ovf_flag),
        .run_active (run_active)
    );

    function automatic logic [31:0] mk(bit run, bit pbuf, bit off, bit src,
                                       bit [1:0] mode, bit wide);
        return {25'd0, wide, mode, src, off, pbuf, run};
    endfunction

    function automatic longint exp_val(int m, int p, int t);
        int ph;
        if (m == 0) return t % (p + 1);
        if (m == 1) return p - (t % (p + 1));
        if (p == 0) return 0;
        ph = t % (2 * p);
        return (ph <= p) ? ph : 2 * p - ph;
    endfunction

    function automatic longint exp_ev(int m, int p, int t);
        if (m < 2) return t / (p + 1);
        if (p == 0) return t;
        return t / p;
    endfunction

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic wait_cnt(input longint v, input string req);
        int k;
        k = 0;
        while (cnt_value != v && k < 200) begin
            step();
            k++;
        end
        chk(req, "reached target value", cnt_value, v);
    endtask

    // steps until the counter wraps to 0 and returns the peak it reached
    task automatic peak_to_wrap(output longint mx);
        int k;
        mx = cnt_value;
        k  = 0;
        do begin
            step();
            if (cnt_value > mx) mx = cnt_value;
            k++;
        end while (cnt_value != 0 && k < 200);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        longint v, mx;
        int     pulses, changes, bad;
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        step();

        // R1 reset state
        do_reset();
        chk("R1", "cnt after reset", cnt_value, 0);
        chk("R1", "flag after reset", ovf_flag, 0);
        chk("R1", "run_active after reset", run_active, 0);
        chk("R1", "pulse after reset", ovf_pulse, 0);

        // R2 enable lag and hold while disabled
        wr(A_PER, 7);
        wr(A_CTRL, mk(1, 0, 0, 0, 2'd0, 0));
        chk("R2", "run_active at write edge", run_active, 0);
        chk("R2", "cnt before enable", cnt_value, 0);
        step();
        chk("R2", "run_active one clock later", run_active, 1);
        chk("R2", "cnt still 0", cnt_value, 0);
        step();
        chk("R3", "first tick", cnt_value, 1);
        step();
        v = cnt_value;
        wr(A_CTRL, mk(0, 0, 0, 0, 2'd0, 0));
        chk("R2", "one more count at disable edge", cnt_value, v + 1);
        step();
        chk("R2", "run_active dropped", run_active, 0);
        chk("R2", "last count", cnt_value, v + 2);
        repeat (4) step();
        chk("R2", "counter holds while disabled", cnt_value, v + 2);

        // R4 divisor deferred until the overflow
        do_reset();
        wr(A_PER, 20);
        wr(A_CTRL, mk(1, 0, 0, 0, 2'd0, 0));
        repeat (3) step();
        wr(A_DIV, 2);
        bad = 0;
        for (int k = 0; k < 40; k++) begin
            v = cnt_value;
            step();
            if (cnt_value != ((v == 20) ? 0 : v + 1)) bad++;
            if (cnt_value == 0) break;
        end
        chk("R4", "old divisor kept until wrap", bad, 0);
        chk("R4", "wrap reached", cnt_value, 0);
        step();
        step();
        chk("R4", "new divisor after event", cnt_value, 0);
        step();
        chk("R4", "first tick of divide-by-3", cnt_value, 1);
        repeat (3) step();
        chk("R3", "second tick of divide-by-3", cnt_value, 2);

        // R8 buffered period
        do_reset();
        wr(A_CTRL, mk(0, 1, 0, 0, 2'd0, 0));
        wr(A_PER, 5);
        wr(A_FLAG, 3);
        wr(A_CTRL, mk(1, 1, 0, 0, 2'd0, 0));
        wait_cnt(2, "R8");
        wr(A_PER, 2);
        peak_to_wrap(mx);
        chk("R8", "buffered period waits for event", mx, 5);
        peak_to_wrap(mx);
        chk("R8", "buffered period after event", mx, 2);

        // R8 direct period
        do_reset();
        wr(A_PER, 9);
        wr(A_CTRL, mk(1, 0, 0, 0, 2'd0, 0));
        wait_cnt(3, "R8");
        wr(A_PER, 5);
        peak_to_wrap(mx);
        chk("R8", "direct period applies at once", mx, 5);

        // R9 event suppressed
        do_reset();
        wr(A_CTRL, mk(0, 1, 0, 0, 2'd0, 0));
        wr(A_PER, 3);
        wr(A_FLAG, 3);
        wr(A_FLAG, 0);
        wr(A_DIV, 2);
        wr(A_PER, 6);
        wr(A_CTRL, mk(1, 1, 1, 0, 2'd0, 0));
        step();
        pulses = 0;
        changes = 0;
        mx = 0;
        for (int k = 0; k < 16; k++) begin
            if (ovf_pulse) pulses++;
            v = cnt_value;
            step();
            if (cnt_value != v) changes++;
            if (cnt_value > mx) mx = cnt_value;
        end
        chk("R9", "no pulse when off", pulses, 0);
        chk("R9", "no flag when off", ovf_flag, 0);
        chk("R9", "period not transferred", mx, 3);
        chk("R9", "divisor not transferred", changes, 16);

        // R10 source select
        do_reset();
        wr(A_PER, 9);
        wr(A_CTRL, mk(1, 0, 0, 1, 2'd0, 0));
        repeat (3) step();
        v = cnt_value;
        wr(A_FLAG, 3);
        chk("R10", "request ignored, cnt runs on", cnt_value, v + 1);
        chk("R10", "request ignored, no flag", ovf_flag, 0);
        wr(A_CTRL, mk(1, 0, 0, 0, 2'd0, 0));
        wr(A_FLAG, 3);
        chk("R10", "request restarts counter", cnt_value, 0);
        chk("R10", "request sets flag", ovf_flag, 1);

        // R11 flag priority and clear
        do_reset();
        wr(A_PER, 3);
        wr(A_CTRL, mk(1, 0, 0, 0, 2'd0, 0));
        wait_cnt(3, "R11");
        chk("R5", "pulse before wrap", ovf_pulse, 1);
        wr(A_FLAG, 0);
        chk("R11", "set wins over clear", ovf_flag, 1);
        chk("R5", "wrapped to 0", cnt_value, 0);
        wr(A_FLAG, 0);
        chk("R11", "clear by writing 0", ovf_flag, 0);
        wr(A_FLAG, 1);
        chk("R11", "writing 1 has no effect", ovf_flag, 0);

        // R12 wide and narrow period
        do_reset();
        wr(A_CTRL, mk(0, 0, 0, 0, 2'd1, 1));
        wr(A_PER, 32'h0001_0001);
        wr(A_FLAG, 3);
        chk("R12", "wide load", cnt_value, 32'h0001_0001);
        wr(A_CTRL, mk(1, 0, 0, 0, 2'd1, 1));
        step();
        step();
        chk("R12", "wide down step", cnt_value, 32'h0001_0000);
        step();
        chk("R12", "wide crosses 16-bit boundary", cnt_value, 32'h0000_FFFF);
        do_reset();
        wr(A_CTRL, mk(0, 0, 0, 0, 2'd1, 0));
        wr(A_PER, 32'h0001_0001);
        wr(A_FLAG, 3);
        chk("R12", "narrow uses low half", cnt_value, 1);

        // R5 R6 R7 sweep over mode, divisor, period
        for (int m = 0; m < 3; m++) begin
            for (int d = 0; d < 3; d++) begin
                for (int p = 0; p < 4; p++) begin
                    int ev, tk, nmax, t;
                    string tag;
                    tag = (m == 0) ? "R5" : (m == 1) ? "R6" : "R7";
                    do_reset();
                    wr(A_CTRL, mk(0, 0, 0, 0, 2'(m), 0));
                    wr(A_DIV, 32'(d));
                    wr(A_PER, 32'(p));
                    wr(A_FLAG, 3);
                    chk("R10", "software event sets flag", ovf_flag, 1);
                    wr(A_FLAG, 0);
                    chk("R11", "flag cleared", ovf_flag, 0);
                    wr(A_CTRL, mk(1, 0, 0, 0, 2'(m), 0));
                    step();
                    ev = 0;
                    tk = 0;
                    nmax = (d + 1) * (2 * p + 3) * 2;
                    chk(tag, "start value", cnt_value, exp_val(m, p, 0));
                    for (int j = 1; j <= nmax; j++) begin
                        if (ovf_pulse) ev++;
                        if (cnt_tick) tk++;
                        step();
                        t = j / (d + 1);
                        chk(tag, "count value", cnt_value, exp_val(m, p, t));
                    end
                    chk("R3", "tick count", tk, nmax / (d + 1));
                    chk(tag, "event count", ev, exp_ev(m, p, nmax / (d + 1)));
                    chk("R11", "flag after run", ovf_flag, (ev > 0) ? 1 : 0);
                end
            end
        end

        done = 1'b1;
        report();
    end

endmodule